// File: doc/BRIEF.md
# Mesh Tile Router with Stall Watchdog

This block is the switching element of one tile in a two-dimensional mesh that carries fixed 64-bit packets. It has five ports: four that face the neighbouring tiles and one that faces the local endpoint. Every port has a valid/ready input side with its own FIFO and a valid/ready output side. A packet's route is decided only by its 6-bit destination tile ID. The ID splits into a 3-bit column and a 3-bit row. The router clears the column difference first and only then moves along the row. Because routing is deterministic and each input is a FIFO, packets that travel the same path keep their order.

Congestion normally produces backpressure and nothing else. The one exception is a per-output stall watchdog. When a packet has sat on an output whose neighbour refuses it for more than a parameterised number of consecutive cycles, the router discards that packet. In the same cycle it pulses an overflow flag and presents the discarded packet's source ID, so the event can be reported back to the sender. Contention for an output is settled round-robin. Once a packet is offered on an output, it stays there until it is taken or discarded.

Top module: `mesh_router`

## Requirements
- R1: Packet bits 5:0 are the destination ID and bits 11:6 the source ID. The column is ID bits 2:0 and the row is ID bits 5:3. All other bits pass through unchanged.
- R2: Ports are indexed 0 local, 1 north, 2 east, 3 south, 4 west, and port i occupies bits i*64+63 down to i*64 of a data bus. If the destination column is larger than MY_X the packet leaves on east. If it is smaller it leaves on west. The row plays no part in this choice.
- R3: If the columns match, the packet leaves on south when the destination row is larger than MY_Y, on north when it is smaller, and on local when both coordinates match.
- R4: On an idle router, a packet accepted at a clock edge is shown as valid on its output starting from that same edge.
- R5: in_ready of a port is low exactly while its FIFO holds FIFO_DEPTH packets. No packet is lost while backpressure is applied.
- R6: For any pair of input and output, packets leave in the order they arrived. Each packet leaves exactly once unless the watchdog discards it.
- R7: When several inputs compete for one output, the grants rotate round-robin. Two inputs that always have traffic are served alternately.
- R8: While out_valid is high and out_ready is low, the packet on that output does not change, unless the watchdog discards it.
- R9: A packet whose output has been refused for more than DROP_LIMIT consecutive cycles is discarded in the (DROP_LIMIT+1)-th such cycle. In that cycle ovf_pulse is high for one cycle and ovf_src carries the packet's source ID.
- R10: A packet refused for exactly DROP_LIMIT cycles and then accepted is delivered, and no overflow pulse occurs.
- R11: After a discard, the next packet on that output begins a new stall count.
- R12: If several outputs reach the limit in the same cycle, only one is discarded per cycle, lowest port index first. The others follow in later cycles.
- R13: During and right after reset, every in_ready is high, every out_valid is low and ovf_pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Packet offered on each input port |
| in_ready | output | 5 | Input FIFO has room |
| in_data | input | 320 | Five packets, one per input port |
| out_valid | output | 5 | Packet offered on each output port |
| out_ready | input | 5 | Neighbour accepts from each output port |
| out_data | output | 320 | Five packets, one per output port |
| ovf_pulse | output | 1 | One-cycle flag: a stalled packet was discarded |
| ovf_src | output | 6 | Source ID of the discarded packet |

## Verification
A discard on one output can fall in the same cycle as a normal transfer or a new grant on another output. Two outputs can also reach the stall limit in the same cycle. The bench blocks east and west together, loads both in one cycle, and expects the east packet's source ID on the first pulse and the west one on the next cycle. The bench also blocks one output for exactly the limit and then releases it, to show that the release wins over the discard. It then mixes random traffic with random ready gaps while checking order per input/output pair and that no unexpected pulse occurs.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;

   localparam int PKT_W   = 64;
   localparam int ID_W    = 6;
   localparam int COORD_W = 3;
   localparam int NPORTS  = 5;
   localparam int DST_LSB = 0;
   localparam int SRC_LSB = 6;

   // Port index order is fixed; the drop priority and the bus slicing rely on it
   typedef enum logic [2:0] {
      PORT_LOCAL = 3'd0,
      PORT_NORTH = 3'd1,
      PORT_EAST  = 3'd2,
      PORT_SOUTH = 3'd3,
      PORT_WEST  = 3'd4
   } port_e;

endpackage

// File: rtl/mr_fifo.sv
module mr_fifo #(
   parameter int WIDTH = 64,
   parameter int DEPTH = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   output logic             full,
   input  logic             pop,
   output logic             avail,
   output logic [WIDTH-1:0] head
);

   localparam int  AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int  CW   = $clog2(DEPTH + 1);
   localparam bit  POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("mr_fifo: DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt;
   logic [AW-1:0]    wptr_nxt, rptr_nxt;

   // Pointer wrap: free running for power-of-two depths, compare otherwise
   if (POW2) begin : g_wrap_free
      assign wptr_nxt = wptr + AW'(1);
      assign rptr_nxt = rptr + AW'(1);
   end else begin : g_wrap_cmp
      assign wptr_nxt = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      assign rptr_nxt = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
   end

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push) wptr <= wptr_nxt;
         if (pop)  rptr <= rptr_nxt;
         case ({push, pop})
            2'b10:   cnt <= cnt + CW'(1);
            2'b01:   cnt <= cnt - CW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   assign full  = (cnt == CW'(DEPTH));
   assign avail = (cnt != '0);
   assign head  = mem[rptr];

   // R5
   no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R6
   pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> avail);

endmodule

// File: rtl/mr_route.sv
module mr_route
   import mesh_router_pkg::*;
#(
   parameter int CRD_W = 3,
   parameter int MY_X  = 0,
   parameter int MY_Y  = 0
)(
   input  logic [2*CRD_W-1:0] dst,
   output port_e              dir
);

   if (MY_X < 0 || MY_X >= (1 << CRD_W) || MY_Y < 0 || MY_Y >= (1 << CRD_W)) begin : g_bad_coord
      $error("mr_route: own coordinate outside the grid");
   end

   logic [CRD_W-1:0] col, row;
   assign col = dst[CRD_W-1:0];
   assign row = dst[2*CRD_W-1:CRD_W];

   // Column first, then row
   always_comb begin
      if (col > CRD_W'(MY_X))       dir = PORT_EAST;
      else if (col < CRD_W'(MY_X))  dir = PORT_WEST;
      else if (row > CRD_W'(MY_Y))  dir = PORT_SOUTH;
      else if (row < CRD_W'(MY_Y))  dir = PORT_NORTH;
      else                          dir = PORT_LOCAL;
   end

endmodule

// File: rtl/mr_out_port.sv
module mr_out_port #(
   parameter int NIN        = 5,
   parameter int WIDTH      = 64,
   parameter int DROP_LIMIT = 1024
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NIN-1:0]       req,
   input  logic [NIN*WIDTH-1:0] cand_data,
   input  logic                 out_ready,
   input  logic                 drop_ok,
   output logic                 out_valid,
   output logic [WIDTH-1:0]     out_data,
   output logic [NIN-1:0]       gnt,
   output logic                 fire,
   output logic                 drop_req,
   output logic                 drop
);

   localparam int IW   = $clog2(NIN);
   localparam int CNTW = $clog2(DROP_LIMIT + 1);

   if (NIN < 2) begin : g_bad_nin
      $error("mr_out_port: NIN must be at least 2");
   end
   if (DROP_LIMIT < 1) begin : g_bad_limit
      $error("mr_out_port: DROP_LIMIT must be at least 1");
   end

   logic            busy;
   logic [IW-1:0]   owner, rr_ptr, pick, sel;
   logic            found;
   int              idx;
   logic [CNTW-1:0] wcnt;
   logic            stalled;

   // Round-robin search starting at the pointer
   always_comb begin
      pick  = rr_ptr;
      found = 1'b0;
      idx   = 0;
      for (int k = 0; k < NIN; k++) begin
         idx = (int'(rr_ptr) + k) % NIN;
         if (!found && req[idx]) begin
            pick  = IW'(idx);
            found = 1'b1;
         end
      end
   end

   assign sel       = busy ? owner : pick;
   assign out_valid = busy | (|req);
   assign out_data  = cand_data[int'(sel)*WIDTH +: WIDTH];
   assign gnt       = out_valid ? (NIN'(1) << sel) : '0;
   assign stalled   = out_valid & ~out_ready;
   assign fire      = out_valid & out_ready;
   assign drop_req  = stalled && (wcnt == CNTW'(DROP_LIMIT));
   assign drop      = drop_req & drop_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         owner  <= '0;
         rr_ptr <= '0;
         wcnt   <= '0;
      end else if (fire || drop) begin
         busy   <= 1'b0;
         rr_ptr <= (sel == IW'(NIN - 1)) ? '0 : sel + IW'(1);
         wcnt   <= '0;
      end else if (out_valid) begin
         busy  <= 1'b1;
         owner <= sel;
         if (wcnt != CNTW'(DROP_LIMIT)) wcnt <= wcnt + CNTW'(1);
      end else begin
         wcnt <= '0;
      end
   end

   // R8
   hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !drop) |=> (out_valid && $stable(out_data)));

   // R9
   drop_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drop |-> $past(out_valid && !out_ready));

endmodule

// File: rtl/mesh_router.sv
module mesh_router
   import mesh_router_pkg::*;
#(
   parameter int MY_X       = 0,
   parameter int MY_Y       = 0,
   parameter int FIFO_DEPTH = 4,
   parameter int DROP_LIMIT = 1024
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NPORTS-1:0]       in_valid,
   output logic [NPORTS-1:0]       in_ready,
   input  logic [NPORTS*PKT_W-1:0] in_data,
   output logic [NPORTS-1:0]       out_valid,
   input  logic [NPORTS-1:0]       out_ready,
   output logic [NPORTS*PKT_W-1:0] out_data,
   output logic                    ovf_pulse,
   output logic [ID_W-1:0]         ovf_src
);

   localparam int NP = NPORTS;

   if (2 * COORD_W != ID_W) begin : g_bad_id
      $error("mesh_router: ID width must hold two coordinates");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_fifo
      $error("mesh_router: FIFO_DEPTH must be at least 2");
   end
   if (DROP_LIMIT < 1) begin : g_bad_drop
      $error("mesh_router: DROP_LIMIT must be at least 1");
   end

   logic [NP-1:0]       fifo_full, fifo_avail, push, pop;
   logic [PKT_W-1:0]    head [NP];
   port_e               dir [NP];
   logic [NP*PKT_W-1:0] head_flat;
   logic [NP-1:0]       req_to [NP];
   logic [NP-1:0]       gnt_of [NP];
   logic [NP-1:0]       fire_o, drop_req, drop_ok, drop_o;

   // Input side: FIFO plus route decision on its head
   for (genvar i = 0; i < NP; i++) begin : g_in
      assign in_ready[i] = ~fifo_full[i];
      assign push[i]     = in_valid[i] & ~fifo_full[i];

      mr_fifo #(
         .WIDTH (PKT_W),
         .DEPTH (FIFO_DEPTH)
      ) u_fifo (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (push[i]),
         .push_data (in_data[i*PKT_W +: PKT_W]),
         .full      (fifo_full[i]),
         .pop       (pop[i]),
         .avail     (fifo_avail[i]),
         .head      (head[i])
      );

      mr_route #(
         .CRD_W (COORD_W),
         .MY_X  (MY_X),
         .MY_Y  (MY_Y)
      ) u_route (
         .dst (head[i][DST_LSB +: ID_W]),
         .dir (dir[i])
      );

      assign head_flat[i*PKT_W +: PKT_W] = head[i];
   end

   always_comb begin
      for (int o = 0; o < NP; o++) begin
         for (int i = 0; i < NP; i++) begin
            req_to[o][i] = fifo_avail[i] && (dir[i] == port_e'(o));
         end
      end
   end

   // Output side: arbiter and watchdog per port
   for (genvar o = 0; o < NP; o++) begin : g_out
      mr_out_port #(
         .NIN        (NP),
         .WIDTH      (PKT_W),
         .DROP_LIMIT (DROP_LIMIT)
      ) u_port (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req_to[o]),
         .cand_data (head_flat),
         .out_ready (out_ready[o]),
         .drop_ok   (drop_ok[o]),
         .out_valid (out_valid[o]),
         .out_data  (out_data[o*PKT_W +: PKT_W]),
         .gnt       (gnt_of[o]),
         .fire      (fire_o[o]),
         .drop_req  (drop_req[o]),
         .drop      (drop_o[o])
      );
   end

   // Only one discard per cycle, lowest port index wins
   always_comb begin
      logic blocked;
      blocked = 1'b0;
      for (int o = 0; o < NP; o++) begin
         drop_ok[o] = ~blocked;
         blocked    = blocked | drop_req[o];
      end
   end

   always_comb begin
      pop = '0;
      for (int o = 0; o < NP; o++) begin
         for (int i = 0; i < NP; i++) begin
            if (gnt_of[o][i] && (fire_o[o] || drop_o[o])) pop[i] = 1'b1;
         end
      end
   end

   always_comb begin
      ovf_pulse = |drop_o;
      ovf_src   = '0;
      for (int o = 0; o < NP; o++) begin
         if (drop_o[o]) ovf_src = out_data[o*PKT_W + SRC_LSB +: ID_W];
      end
   end

   // R12
   one_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drop_o));

endmodule

// File: tb/mesh_router_tb.sv
module mesh_router_tb;

   localparam int MY_X  = 3;
   localparam int MY_Y  = 4;
   localparam int DEPTH = 4;
   localparam int LIMIT = 16;

   logic         clk = 1'b0;
   logic         rst_n;
   logic [4:0]   in_valid, in_ready, out_valid, out_ready;
   logic [319:0] in_data, out_data;
   logic         ovf_pulse;
   logic [5:0]   ovf_src;

   int  nchecks = 0;
   int  nerr = 0;
   bit  done = 1'b0;
   bit  ovf_ok = 1'b0;
   logic [4:0]  took;
   int          delivered [5];
   logic [63:0] expq [25][$];
   logic [4:0]  prev_stall;
   logic        prev_ovf;
   logic [63:0] prev_data [5];

   always #10 clk = ~clk;

   mesh_router #(
      .MY_X       (MY_X),
      .MY_Y       (MY_Y),
      .FIFO_DEPTH (DEPTH),
      .DROP_LIMIT (LIMIT)
   ) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .out_data  (out_data),
      .ovf_pulse (ovf_pulse),
      .ovf_src   (ovf_src)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchecks++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Model of the routing rule (R2, R3)
   function automatic int exp_port(input logic [5:0] d);
      int x, y;
      x = int'(d[2:0]);
      y = int'(d[5:3]);
      if (x > MY_X) return 2;
      if (x < MY_X) return 4;
      if (y > MY_Y) return 3;
      if (y < MY_Y) return 1;
      return 0;
   endfunction

   function automatic logic [5:0] tile(input int x, input int y);
      return 6'(y * 8 + x);
   endfunction

   // src bits 8:6 mark the input port the bench used
   function automatic logic [63:0] mk_pkt(input int inp, input logic [5:0] d);
      logic [63:0] p;
      p = {$urandom(), $urandom()};
      p[5:0] = d;
      p[8:6] = 3'(inp);
      return p;
   endfunction

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic send(input int i, input logic [63:0] p);
      in_valid[i] = 1'b1;
      in_data[i*64 +: 64] = p;
      step();
      in_valid[i] = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = '0;
      in_data = '0;
      out_ready = '1;
      ovf_ok = 1'b0;
      for (int k = 0; k < 25; k++) expq[k].delete();
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   // Scoreboard and hold monitor, sampled away from the active edge
   always @(negedge clk) begin
      logic [63:0] p, e;
      int s;
      if (!rst_n) begin
         took = '0;
         prev_stall = '0;
         prev_ovf = 1'b0;
         for (int o = 0; o < 5; o++) delivered[o] = 0;
      end else begin
         for (int i = 0; i < 5; i++) begin
            took[i] = in_valid[i] && in_ready[i];
            if (took[i]) begin
               p = in_data[i*64 +: 64];
               expq[i*5 + exp_port(p[5:0])].push_back(p);
            end
         end
         for (int o = 0; o < 5; o++) begin
            p = out_data[o*64 +: 64];
            if (prev_stall[o] && !prev_ovf)
               chk(out_valid[o] && p == prev_data[o], "R8 hold while refused", p, prev_data[o]);
            if (out_valid[o] && out_ready[o]) begin
               delivered[o]++;
               s = int'(p[8:6]);
               if (s > 4 || expq[s*5 + o].size() == 0) begin
                  chk(1'b0, "R6 R2 R3 unexpected packet on output", p, 64'(o));
               end else begin
                  e = expq[s*5 + o].pop_front();
                  chk(p == e, "R6 R1 order and content", p, e);
               end
            end
            prev_stall[o] = out_valid[o] && !out_ready[o];
            prev_data[o] = p;
         end
         prev_ovf = ovf_pulse;
         if (ovf_pulse && !ovf_ok) chk(1'b0, "R10 unexpected discard", 64'(ovf_src), 64'd0);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
         $finish;
      end
   end

   initial begin
      int cx [6];
      int cy [6];
      int stalls, pt, left, nseq;
      logic [63:0] p, p1, p2, pe, pw;
      logic [2:0] seq [4];

      do_reset();

      // R13 reset state
      @(negedge clk);
      chk(in_ready == 5'h1f && out_valid == 5'h0 && !ovf_pulse, "R13 reset state",
          {54'd0, in_ready, out_valid}, {54'd0, 5'h1f, 5'h0});

      // R2 R3 R4 directed routes, including column-first with row offset
      cx = '{5, 0, 3, 3, 3, 7};
      cy = '{0, 7, 0, 7, 4, 7};
      for (int k = 0; k < 6; k++) begin
         step();
         p = mk_pkt(0, tile(cx[k], cy[k]));
         pt = exp_port(p[5:0]);
         send(0, p);
         @(negedge clk);
         chk(out_valid == (5'd1 << pt) && out_data[pt*64 +: 64] == p,
             (cx[k] != MY_X) ? "R2 R4 column route" : "R3 R4 row or local route",
             out_data[pt*64 +: 64], p);
      end

      // R5 backpressure on north, then ordered drain
      do_reset();
      out_ready[1] = 1'b0;
      for (int k = 0; k < DEPTH; k++) send(0, mk_pkt(0, tile(MY_X, 1)));
      in_valid[0] = 1'b1;
      in_data[63:0] = mk_pkt(0, tile(MY_X, 0));
      @(negedge clk);
      chk(in_ready[0] == 1'b0, "R5 in_ready low when full", 64'(in_ready[0]), 64'd0);
      step();
      step();
      in_valid[0] = 1'b0;
      out_ready[1] = 1'b1;
      repeat (12) step();
      @(negedge clk);
      chk(delivered[1] == DEPTH && expq[1].size() == 0, "R5 R6 all held packets delivered",
          64'(delivered[1]), 64'(DEPTH));

      // R7 round-robin between north and south inputs heading east
      do_reset();
      out_ready[2] = 1'b0;
      for (int k = 0; k < 2; k++) begin
         in_valid[1] = 1'b1;
         in_valid[3] = 1'b1;
         in_data[64 +: 64] = mk_pkt(1, tile(6, MY_Y));
         in_data[192 +: 64] = mk_pkt(3, tile(6, MY_Y));
         step();
      end
      in_valid = '0;
      out_ready[2] = 1'b1;
      nseq = 0;
      repeat (8) begin
         @(negedge clk);
         if (out_valid[2] && out_ready[2] && nseq < 4) begin
            seq[nseq] = out_data[2*64 + 8 -: 3];
            nseq++;
         end
      end
      for (int k = 0; k < 4; k++)
         chk(nseq == 4 && seq[k] == ((k % 2 == 0) ? 3'd1 : 3'd3), "R7 alternating grants",
             64'(seq[k]), (k % 2 == 0) ? 64'd1 : 64'd3);
      step();

      // R9 R11 discard after the limit, next packet gets a new count
      do_reset();
      ovf_ok = 1'b1;
      out_ready[2] = 1'b0;
      p1 = mk_pkt(0, tile(7, 2));
      p2 = mk_pkt(0, tile(6, 6));
      send(0, p1);
      send(0, p2);
      stalls = 1;  // first refused cycle passed while p2 was being sent
      for (int k = 0; k < 3 * LIMIT; k++) begin
         @(negedge clk);
         if (ovf_pulse) break;
         if (out_valid[2] && !out_ready[2]) stalls++;
      end
      chk(ovf_pulse && stalls == LIMIT, "R9 discard after limit", 64'(stalls), 64'(LIMIT));
      chk(ovf_src == p1[11:6], "R9 R1 overflow source", 64'(ovf_src), 64'(p1[11:6]));
      if (expq[2].size() != 0) void'(expq[2].pop_front());
      @(negedge clk);
      chk(!ovf_pulse, "R9 pulse lasts one cycle", 64'(ovf_pulse), 64'd0);
      chk(out_valid[2] && out_data[2*64 +: 64] == p2, "R11 next packet offered fresh",
          out_data[2*64 +: 64], p2);
      step();
      out_ready[2] = 1'b1;
      ovf_ok = 1'b0;
      repeat (3) step();
      @(negedge clk);
      chk(expq[2].size() == 0, "R11 next packet delivered", 64'(expq[2].size()), 64'd0);

      // R10 refused for exactly the limit, then accepted
      do_reset();
      out_ready[4] = 1'b0;
      p = mk_pkt(0, tile(0, MY_Y));
      send(0, p);
      stalls = 0;
      while (stalls < LIMIT) begin
         @(negedge clk);
         if (out_valid[4] && !out_ready[4]) stalls++;
      end
      step();
      out_ready[4] = 1'b1;
      @(negedge clk);
      chk(out_valid[4] && out_data[4*64 +: 64] == p && !ovf_pulse, "R10 delivered at the limit",
          out_data[4*64 +: 64], p);
      step();

      // R12 two outputs reach the limit together
      do_reset();
      ovf_ok = 1'b1;
      out_ready[2] = 1'b0;
      out_ready[4] = 1'b0;
      pe = mk_pkt(0, tile(5, 5));
      pw = mk_pkt(1, tile(1, 1));
      in_valid[0] = 1'b1;
      in_valid[1] = 1'b1;
      in_data[0 +: 64] = pe;
      in_data[64 +: 64] = pw;
      step();
      in_valid = '0;
      for (int k = 0; k < 3 * LIMIT; k++) begin
         @(negedge clk);
         if (ovf_pulse) break;
      end
      chk(ovf_pulse && ovf_src == pe[11:6], "R12 lower port discarded first",
          64'(ovf_src), 64'(pe[11:6]));
      if (expq[2].size() != 0) void'(expq[2].pop_front());
      @(negedge clk);
      chk(ovf_pulse && ovf_src == pw[11:6], "R12 second discard next cycle",
          64'(ovf_src), 64'(pw[11:6]));
      if (expq[9].size() != 0) void'(expq[9].pop_front());
      step();
      ovf_ok = 1'b0;
      out_ready = '1;

      // Random traffic with random refusals (R2 R3 R6 R8)
      do_reset();
      void'($urandom(32'h5eed_1234));
      for (int c = 0; c < 4000; c++) begin
         for (int i = 0; i < 5; i++) begin
            if (!in_valid[i] || took[i]) begin
               if ($urandom() % 3 == 0) begin
                  in_valid[i] = 1'b1;
                  in_data[i*64 +: 64] = mk_pkt(i, 6'($urandom() % 64));
               end else begin
                  in_valid[i] = 1'b0;
               end
            end
         end
         for (int o = 0; o < 5; o++) out_ready[o] = ($urandom() % 4) != 0;
         step();
      end
      in_valid = '0;
      out_ready = '1;
      repeat (40) step();
      @(negedge clk);
      left = 0;
      for (int k = 0; k < 25; k++) left += expq[k].size();
      chk(left == 0, "R6 every random packet delivered", 64'(left), 64'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
   end

endmodule